// File: doc/BRIEF.md
# Masked Base Address Hit Decoder

This block tells the bus fabric whether the current access lands in one of two memory blocks. Each block is described by a valid flag, a 14-bit base that is compared against the upper address bits, a matching 14-bit mask, a write-protect flag and a 2-bit port-size code. A mask bit set to 1 takes the matching address bit out of the comparison, so a single base can cover a power-of-two sized and aligned window, or a sparse set of windows.

While an access strobe is present, the decoder reports combinationally whether a block was hit, which block it was, and the data port width of that block as a one-hot code. A write that lands in a write-protected block is not reported as a hit. Instead, a registered access-exception pulse is raised one clock later. Reads from a protected block are served normally. When both blocks match, block 0 wins.

Top module: `addr_hit_decoder`

## Requirements
- R1: A block matches only when the address bits 31 to 18 equal its base field bit for bit. Bit k of the base is compared with address bit 18+k. Address bits 17 to 0 never affect the decode.
- R2: Mask bit k set to 1 excludes address bit 18+k from the comparison. Mask bit k set to 0 keeps that bit in the comparison. With every mask bit set, any address matches a valid block.
- R3: A block whose valid input is 0 never produces a hit and never causes an exception.
- R4: A write strobe (`bus_wr`=1) that matches a block whose write-protect input is 1 gives `hit`=0 and `port_width`=0.
- R5: A read strobe (`bus_wr`=0) that matches a write-protected block is reported as a normal hit, and no exception follows.
- R6: `port_width` is one-hot: bit 0 means 8 bits, bit 1 means 16 bits and bit 2 means 32 bits. Port-size code 00 gives 32 bits, code 01 gives 8 bits, and codes 10 and 11 give 16 bits. `port_width` is 0 whenever `hit` is 0.
- R7: When both blocks match, block 0 is selected (`hit_blk`=0). This holds for the hit, the width and the protection check. `hit_blk`=1 only when block 0 does not match.
- R8: `acc_exc` is registered. It is 1 for exactly the one clock after each rising edge at which a write strobe matched a selected write-protected block, and it is 0 otherwise.
- R9: With `bus_strobe`=0, `hit` and `port_width` are 0 and no exception follows, whatever the address.
- R10: A synchronous active-high `rst` clears `acc_exc`, even when an offending write is sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Bus address |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_strobe | input | 1 | Access present this cycle |
| blk_valid | input | 2 | Per-block enable, bit i for block i |
| blk_base | input | 28 | Block bases, 14 bits each, block 0 in bits 13:0 |
| blk_mask | input | 28 | Block masks, 14 bits each, block 0 in bits 13:0 |
| blk_wprot | input | 2 | Per-block write protect |
| blk_psize | input | 4 | Port-size codes, 2 bits each, block 0 in bits 1:0 |
| hit | output | 1 | Access hits a block and is allowed |
| hit_blk | output | 1 | Index of the selected block |
| port_width | output | 3 | One-hot port width of the hit block |
| acc_exc | output | 1 | Registered write-protect exception pulse |

## Verification
Several properties are checked on every clock by assertions. A reported hit always names a valid block, and never a protected block on a write. The width code is one-hot and present exactly when there is a hit. Block 1 is only named when block 0 does not match. An exception pulse is always preceded by a write strobe.

Other behaviour is shown only by the bench's scenarios, which compare each result against an independent model. These cover the bit-exact masked comparison, the mapping of each size code, and the choice of which write produces an exception. They also cover the one-cycle shape of that pulse and its clearing by a reset at the same edge.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 18;
    localparam int FIELD_W  = ADDR_W - BASE_LSB;
    localparam int NUM_BLK  = 2;
    localparam int IDX_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam int PS_W     = 2;
    localparam int WOH_W    = 3;

    typedef enum logic [PS_W-1:0] {
        PSZ_32  = 2'b00,
        PSZ_8   = 2'b01,
        PSZ_16A = 2'b10,
        PSZ_16B = 2'b11
    } psize_e;

    typedef logic [WOH_W-1:0] width_oh_t;

    localparam width_oh_t WOH_NONE = 3'b000;
    localparam width_oh_t WOH_8    = 3'b001;
    localparam width_oh_t WOH_16   = 3'b010;
    localparam width_oh_t WOH_32   = 3'b100;

    typedef struct packed {
        logic               valid;
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] mask;
        logic               wprot;
        psize_e             psize;
    } blk_cfg_t;

    typedef struct packed {
        logic             any;
        logic [IDX_W-1:0] idx;
        logic             wprot;
        psize_e           psize;
    } sel_t;

    function automatic width_oh_t width_of(psize_e code);
        width_oh_t w;
        case (code)
            PSZ_32:  w = WOH_32;
            PSZ_8:   w = WOH_8;
            default: w = WOH_16;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/blk_match.sv
module blk_match #(
    parameter int FIELD_W = mbd_pkg::FIELD_W
) (
    input  logic [FIELD_W-1:0] addr_field,
    input  logic               valid,
    input  logic [FIELD_W-1:0] base,
    input  logic [FIELD_W-1:0] mask,
    output logic               match
);
    logic [FIELD_W-1:0] diff;

    always_comb begin
        diff  = (addr_field ^ base) & ~mask;
        match = valid && (diff == '0);
    end
endmodule

// File: rtl/hit_select.sv
module hit_select
    import mbd_pkg::*;
#(
    parameter int N = NUM_BLK
) (
    input  logic [N-1:0]      match,
    input  blk_cfg_t [N-1:0]  cfg,
    output sel_t              sel
);
    always_comb begin
        sel = '{any: 1'b0, idx: '0, wprot: 1'b0, psize: PSZ_32};
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel.any   = 1'b1;
                sel.idx   = IDX_W'(i);
                sel.wprot = cfg[i].wprot;
                sel.psize = cfg[i].psize;
            end
        end
    end
endmodule

// File: rtl/exc_pulse.sv
module exc_pulse (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic exc
);
    always_ff @(posedge clk) begin
        if (rst) exc <= 1'b0;
        else     exc <= fire;
    end
endmodule

// File: rtl/addr_hit_decoder.sv
module addr_hit_decoder
    import mbd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_strobe,
    input  logic [NUM_BLK-1:0]           blk_valid,
    input  logic [NUM_BLK*FIELD_W-1:0]   blk_base,
    input  logic [NUM_BLK*FIELD_W-1:0]   blk_mask,
    input  logic [NUM_BLK-1:0]           blk_wprot,
    input  logic [NUM_BLK*PS_W-1:0]      blk_psize,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_blk,
    output logic [WOH_W-1:0]             port_width,
    output logic                         acc_exc
);
    blk_cfg_t [NUM_BLK-1:0] cfg;
    logic     [NUM_BLK-1:0] match;
    logic     [FIELD_W-1:0] addr_field;
    sel_t                   sel;
    logic                   blocked;
    logic                   fire;

    assign addr_field = bus_addr[ADDR_W-1:BASE_LSB];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
        assign cfg[g].valid = blk_valid[g];
        assign cfg[g].base  = blk_base[g*FIELD_W +: FIELD_W];
        assign cfg[g].mask  = blk_mask[g*FIELD_W +: FIELD_W];
        assign cfg[g].wprot = blk_wprot[g];
        assign cfg[g].psize = psize_e'(blk_psize[g*PS_W +: PS_W]);

        blk_match #(.FIELD_W(FIELD_W)) u_match (
            .addr_field (addr_field),
            .valid      (cfg[g].valid),
            .base       (cfg[g].base),
            .mask       (cfg[g].mask),
            .match      (match[g])
        );
    end

    hit_select #(.N(NUM_BLK)) u_sel (
        .match (match),
        .cfg   (cfg),
        .sel   (sel)
    );

    always_comb begin
        blocked    = bus_wr && sel.wprot;
        hit        = bus_strobe && sel.any && !blocked;
        hit_blk    = sel.idx;
        port_width = hit ? width_of(sel.psize) : WOH_NONE;
        fire       = bus_strobe && sel.any && blocked;
    end

    exc_pulse u_exc (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .exc  (acc_exc)
    );

    // R3: a reported hit names a valid block
    a_r3_valid_only: assert property (@(posedge clk) disable iff (rst)
        hit |-> blk_valid[hit_blk]);

    // R4: no hit on a protected write
    a_r4_no_prot_write: assert property (@(posedge clk) disable iff (rst)
        (hit && bus_wr) |-> !blk_wprot[hit_blk]);

    // R6: width is one-hot and present only with a hit
    a_r6_width_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_width) && (hit == (port_width != '0)));

    // R7: block 1 named only if block 0 did not match
    a_r7_priority: assert property (@(posedge clk) disable iff (rst)
        (hit && hit_blk != '0) |-> !match[0]);

    // R8: exception always follows a write strobe
    a_r8_exc_after_write: assert property (@(posedge clk) disable iff (rst)
        acc_exc |-> $past(bus_strobe && bus_wr));

    // R9: no hit without a strobe
    a_r9_strobe_gate: assert property (@(posedge clk) disable iff (rst)
        !bus_strobe |-> !hit);
endmodule

// File: tb/addr_hit_decoder_test.sv
module addr_hit_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_strobe = 1'b0;
    logic [1:0]  v = '0;
    logic [13:0] b [2];
    logic [13:0] m [2];
    logic [1:0]  wp = '0;
    logic [1:0]  ps [2];
    logic        hit;
    logic        hit_blk;
    logic [2:0]  port_width;
    logic        acc_exc;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_exc = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    addr_hit_decoder uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_strobe(bus_strobe), .blk_valid(v),
        .blk_base({b[1], b[0]}), .blk_mask({m[1], m[0]}),
        .blk_wprot(wp), .blk_psize({ps[1], ps[0]}),
        .hit(hit), .hit_blk(hit_blk), .port_width(port_width), .acc_exc(acc_exc)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic blk_hits(int i);
        return v[i] && (((bus_addr[31:18] ^ b[i]) & ~m[i]) == 14'd0);
    endfunction

    function automatic logic [2:0] width_exp(logic [1:0] code);
        if (code == 2'b00) return 3'b100;
        if (code == 2'b01) return 3'b001;
        return 3'b010;
    endfunction

    // inputs already set at a negedge; check comb outputs, then the pulse
    task automatic step(string req);
        int  sel = -1;
        logic eh, ef;
        #1;
        if (blk_hits(0)) sel = 0;
        else if (blk_hits(1)) sel = 1;
        eh = bus_strobe && sel >= 0 && !(bus_wr && wp[sel]);
        ef = bus_strobe && sel >= 0 && bus_wr && wp[sel];
        chk({req, " hit"}, hit, eh);
        chk({req, " width"}, port_width, eh ? width_exp(ps[sel]) : 3'b000);
        if (eh) chk({req, " idx"}, hit_blk, sel);
        exp_exc = ef;
        @(negedge clk);
        chk({req, " exc"}, acc_exc, exp_exc);
    endtask

    task automatic cfg_set(int i, logic vv, logic [13:0] bb, logic [13:0] mm,
                           logic ww, logic [1:0] pp);
        v[i] = vv; b[i] = bb; m[i] = mm; wp[i] = ww; ps[i] = pp;
    endtask

    task automatic acc(logic [31:0] a, logic w, logic s);
        bus_addr = a; bus_wr = w; bus_strobe = s;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'h5eed_1234);
        cfg_set(0, 0, 14'h0, 14'h0, 0, 2'b00);
        cfg_set(1, 0, 14'h0, 14'h0, 0, 2'b00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state (R10, R9)
        chk("R10 reset exc", acc_exc, 1'b0);
        chk("R9 idle hit", hit, 1'b0);

        // R1: exact compare, low bits ignored
        cfg_set(0, 1, 14'h2A5, 14'h0, 0, 2'b00);
        cfg_set(1, 1, 14'h1000, 14'h0, 0, 2'b01);
        acc({14'h2A5, 18'h3FFFF}, 0, 1); step("R1 low bits ignored");
        acc({14'h2A4, 18'h0}, 0, 1);     step("R1 one bit off");
        acc({14'h1000, 18'h12345}, 1, 1); step("R1 block1 hit");
        // R2: masked bits
        m[0] = 14'h0003;
        acc({14'h2A6, 18'h0}, 0, 1);     step("R2 masked low bits");
        acc({14'h2AD, 18'h0}, 0, 1);     step("R2 unmasked bit miss");
        m[1] = 14'h3FFF;
        acc(32'hFFFF_FFFF, 0, 1);        step("R2 full mask");
        // R7: both match -> block 0
        m[0] = 14'h3FFF;
        acc(32'h1234_5678, 0, 1);        step("R7 priority");
        // R3: invalid block 0 -> block 1
        v[0] = 0;
        acc(32'h1234_5678, 0, 1);        step("R3 invalid skipped");
        v[1] = 0;
        acc(32'h1234_5678, 1, 1);        step("R3 none valid");
        // R4 / R5: write protect
        cfg_set(0, 1, 14'h0010, 14'h0, 1, 2'b10);
        cfg_set(1, 1, 14'h0010, 14'h0, 0, 2'b01);
        acc({14'h0010, 18'h4}, 1, 1);    step("R4 protected write");
        acc({14'h0010, 18'h4}, 0, 1);    step("R5 protected read");
        acc({14'h0010, 18'h4}, 1, 1);    step("R8 second pulse");
        acc({14'h0010, 18'h4}, 1, 0);    step("R9 no strobe");
        // R6: every size code
        for (int c = 0; c < 4; c++) begin
            ps[0] = 2'(c); wp[0] = 0;
            acc({14'h0010, 18'h0}, 0, 1); step("R6 size code");
        end
        // R10: reset at the same edge as an offending write
        wp[0] = 1;
        acc({14'h0010, 18'h0}, 1, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset beats exc", acc_exc, 1'b0);
        rst = 1'b0;
        acc(32'h0, 0, 0);
        @(negedge clk);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < 2; i++) begin
                v[i]  = ($urandom % 8) != 0;
                b[i]  = 14'($urandom);
                m[i]  = 14'($urandom) & 14'($urandom) & 14'($urandom);
                wp[i] = ($urandom % 3) == 0;
                ps[i] = 2'($urandom);
            end
            if ($urandom % 2) b[1] = b[0];
            case ($urandom % 3)
                0: bus_addr = {b[0] ^ (14'($urandom) & m[0]), 18'($urandom)};
                1: bus_addr = {b[1] ^ (14'($urandom) & m[1]), 18'($urandom)};
                default: bus_addr = $urandom;
            endcase
            bus_wr = 1'($urandom);
            bus_strobe = ($urandom % 5) != 0;
            step("R1-mix random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule